// File: doc/BRIEF.md
# Three-Source Round-Robin Stream Merger

This block merges three AXI-Stream sources onto one AXI-Stream output that feeds a serializer link. Sources have fixed indices: index 0 is the user-logic stream, index 1 is the register-bridge stream and index 2 is the capture-logic stream. Each source carries tdata, tstrb, tkeep, tlast, a 2-bit tuser and tvalid/tready. Sources 0 and 2 also have an urgent-request input. Source 0 additionally carries a sideband field, which reaches the output when the `SB_EN` parameter is set.

Arbitration rotates priority. The request vector, built from the tvalid inputs, is rotated so that the source after the one served last sits at the lowest position. The lowest set bit is picked, and the result is rotated back to a real source index. A request that is both urgent and valid takes precedence over plain requests. Urgent requests compete with each other in the same rotating order.

A two-state controller holds the choice for the length of a packet. The controller states and their transitions are:
- In `ST_IDLE`, the picked source is offered live.
  - `ST_IDLE -> ST_IDLE` with a pointer update: a single-beat packet completes in the cycle it is offered.
  - `ST_IDLE -> ST_HOLD`: an offered beat is stalled, or is accepted without tlast.
- In `ST_HOLD`, the stored source is kept.
  - `ST_HOLD -> ST_HOLD`: any cycle with no accepted tlast beat.
  - `ST_HOLD -> ST_IDLE` with a pointer update: a beat with tlast is accepted.

Every output beat is tagged with a 2-bit tid that names its source.

Top module: `rr_stream_merge`

## Requirements
- R1: After reset, no output beat is offered and every source tready is low while no source is valid. When all three sources are valid, the first source granted is index 0.
- R2: After a packet from source k completes, the next search begins at source (k+1) mod 3. With all sources valid and every beat a single-beat packet, the grants run 0, 1, 2, 0.
- R3: A source whose urgent input and tvalid are both high wins over sources with only tvalid high. When urgent sources 0 and 2 are both valid, the rotating order chooses between them. An urgent input with its tvalid low has no effect on the choice.
- R4: Once a source has been offered, the grant stays with it until a beat with tlast=1 is accepted (m_tvalid and m_tready both high). This holds even when the source drops tvalid mid-packet or another source, urgent or not, requests.
- R5: While m_tvalid is high and m_tready is low, m_tid and the selected payload do not change in the next cycle.
- R6: m_tid equals the granted source index (0, 1 or 2). m_tdata, m_tstrb, m_tkeep, m_tlast and m_tuser are those of that source. m_tvalid is high only when that source's tvalid is high.
- R7: Only the granted source sees tready, and it equals m_tready. The other two sources see tready low.
- R8: When no source is valid and no packet is held, m_tvalid is 0, m_tid is 0, all source tready are 0, and the rotation pointer keeps its value.
- R9: With `SB_EN`=1, m_tsb carries s0_tsb while source 0 is granted and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_tdata | input | DATA_W | Source 0 data |
| s0_tstrb | input | DATA_W/8 | Source 0 byte strobes |
| s0_tkeep | input | DATA_W/8 | Source 0 byte keeps |
| s0_tlast | input | 1 | Source 0 end of packet |
| s0_tuser | input | 2 | Source 0 user bits |
| s0_tsb | input | SB_W | Source 0 sideband |
| s0_urgent | input | 1 | Source 0 urgent request |
| s0_tvalid | input | 1 | Source 0 valid |
| s0_tready | output | 1 | Source 0 ready |
| s1_tdata | input | DATA_W | Source 1 data |
| s1_tstrb | input | DATA_W/8 | Source 1 byte strobes |
| s1_tkeep | input | DATA_W/8 | Source 1 byte keeps |
| s1_tlast | input | 1 | Source 1 end of packet |
| s1_tuser | input | 2 | Source 1 user bits |
| s1_tvalid | input | 1 | Source 1 valid |
| s1_tready | output | 1 | Source 1 ready |
| s2_tdata | input | DATA_W | Source 2 data |
| s2_tstrb | input | DATA_W/8 | Source 2 byte strobes |
| s2_tkeep | input | DATA_W/8 | Source 2 byte keeps |
| s2_tlast | input | 1 | Source 2 end of packet |
| s2_tuser | input | 2 | Source 2 user bits |
| s2_urgent | input | 1 | Source 2 urgent request |
| s2_tvalid | input | 1 | Source 2 valid |
| s2_tready | output | 1 | Source 2 ready |
| m_tdata | output | DATA_W | Merged data |
| m_tstrb | output | DATA_W/8 | Merged byte strobes |
| m_tkeep | output | DATA_W/8 | Merged byte keeps |
| m_tlast | output | 1 | Merged end of packet |
| m_tuser | output | 2 | Merged user bits |
| m_tid | output | 2 | Index of the source of the current beat |
| m_tsb | output | SB_W | Merged sideband (source 0 only) |
| m_tvalid | output | 1 | Merged valid |
| m_tready | input | 1 | Link ready |

## Verification
The hardest situation to reach is an urgent request arriving while another source holds the grant. This can happen in two ways: the held beat is stalled by m_tready low, or the owner drops tvalid between beats of an unfinished packet. The vector table reaches both by holding m_tready low on a multi-beat offer, then raising source 0's urgent input while source 2 still owns the packet and lets tvalid fall. The table then confirms that the urgent source is served only after source 2's tlast beat. A second sequence stalls source 0 while source 2 requests urgently, and checks that tid, data and every tready hold until the tlast handshake.

// File: rtl/rr_merge_pkg.sv
package rr_merge_pkg;
    localparam int N_SRC  = 3;
    localparam int IDX_W  = 2;
    localparam int USER_W = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/rr_rotate_pick.sv
module rr_rotate_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] base,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);
    logic [N-1:0] rot;
    logic [N-1:0] pick;

    function automatic int wrap_idx(input int v);
        return (v >= N) ? v - N : v;
    endfunction

    always_comb begin
        rot = '0;
        for (int k = 0; k < N; k++) begin
            rot[k] = req[wrap_idx(k + int'(base))];
        end
        pick = '0;
        for (int k = 0; k < N; k++) begin
            if (rot[k] && (pick == '0)) begin
                pick[k] = 1'b1;
            end
        end
        gnt_any = |rot;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            if (pick[k]) begin
                gnt_idx = IW'(wrap_idx(k + int'(base)));
            end
        end
    end
endmodule

// File: rtl/rr_grant_fsm.sv
module rr_grant_fsm
    import rr_merge_pkg::*;
#(
    parameter int N  = N_SRC,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_valid,
    input  logic [N-1:0]  src_last,
    input  logic [N-1:0]  src_urgent,
    input  logic          m_ready,
    output logic          sel_on,
    output logic [IW-1:0] sel_idx,
    output logic          m_valid
);
    localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

    arb_state_e    state_q, state_d;
    logic [IW-1:0] hold_q, hold_d;
    logic [IW-1:0] prev_q, prev_d;
    logic [IW-1:0] base;
    logic [N-1:0]  urg_req;
    logic [N-1:0]  cand;
    logic          pick_any;
    logic [IW-1:0] pick_idx;
    logic          fire;
    logic          done;

    assign urg_req = src_urgent & src_valid;
    assign cand    = (|urg_req) ? urg_req : src_valid;
    assign base    = (prev_q == TOP_IDX) ? '0 : prev_q + 1'b1;

    rr_rotate_pick #(.N(N), .IW(IW)) pick_i (
        .req     (cand),
        .base    (base),
        .gnt_any (pick_any),
        .gnt_idx (pick_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            prev_q  <= TOP_IDX;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            prev_q  <= prev_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                sel_on  = pick_any;
                sel_idx = pick_idx;
            end
            ST_HOLD: begin
                sel_on  = 1'b1;
                sel_idx = hold_q;
            end
            default: begin
                sel_on  = 1'b0;
                sel_idx = '0;
            end
        endcase
        m_valid = sel_on && src_valid[sel_idx];
        fire    = m_valid && m_ready;
        done    = fire && src_last[sel_idx];
    end

    // transitions
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        prev_d  = prev_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any) begin
                    if (done) begin
                        prev_d = pick_idx;
                    end else begin
                        state_d = ST_HOLD;
                        hold_d  = pick_idx;
                    end
                end
            end
            ST_HOLD: begin
                if (done) begin
                    state_d = ST_IDLE;
                    prev_d  = hold_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/rr_payload_mux.sv
module rr_payload_mux
    import rr_merge_pkg::*;
#(
    parameter int N     = N_SRC,
    parameter int IW    = IDX_W,
    parameter int DW    = 32,
    parameter int KW    = DW / 8,
    parameter int UW    = USER_W,
    parameter int SBW   = 4,
    parameter bit SB_EN = 1'b1
) (
    input  logic [N-1:0][DW-1:0] src_data,
    input  logic [N-1:0][KW-1:0] src_strb,
    input  logic [N-1:0][KW-1:0] src_keep,
    input  logic [N-1:0]         src_last,
    input  logic [N-1:0][UW-1:0] src_user,
    input  logic [SBW-1:0]       sb_in,
    input  logic                 sel_on,
    input  logic [IW-1:0]        sel_idx,
    input  logic                 m_ready,
    output logic [DW-1:0]        m_data,
    output logic [KW-1:0]        m_strb,
    output logic [KW-1:0]        m_keep,
    output logic                 m_last,
    output logic [UW-1:0]        m_user,
    output logic [IW-1:0]        m_tid,
    output logic [SBW-1:0]       m_sb,
    output logic [N-1:0]         src_ready
);
    always_comb begin
        if (sel_on) begin
            m_data = src_data[sel_idx];
            m_strb = src_strb[sel_idx];
            m_keep = src_keep[sel_idx];
            m_last = src_last[sel_idx];
            m_user = src_user[sel_idx];
            m_tid  = sel_idx;
        end else begin
            m_data = '0;
            m_strb = '0;
            m_keep = '0;
            m_last = 1'b0;
            m_user = '0;
            m_tid  = '0;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_ready
        assign src_ready[i] = sel_on && (sel_idx == IW'(i)) && m_ready;
    end

    if (SB_EN) begin : g_sb_on
        assign m_sb = (sel_on && (sel_idx == '0)) ? sb_in : '0;
    end else begin : g_sb_off
        logic sb_unused;
        assign sb_unused = ^sb_in;
        assign m_sb = '0;
    end
endmodule

// File: rtl/rr_stream_merge.sv
module rr_stream_merge
    import rr_merge_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SB_W   = 4,
    parameter bit SB_EN  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   s0_tdata,
    input  logic [DATA_W/8-1:0] s0_tstrb,
    input  logic [DATA_W/8-1:0] s0_tkeep,
    input  logic                s0_tlast,
    input  logic [1:0]          s0_tuser,
    input  logic [SB_W-1:0]     s0_tsb,
    input  logic                s0_urgent,
    input  logic                s0_tvalid,
    output logic                s0_tready,
    input  logic [DATA_W-1:0]   s1_tdata,
    input  logic [DATA_W/8-1:0] s1_tstrb,
    input  logic [DATA_W/8-1:0] s1_tkeep,
    input  logic                s1_tlast,
    input  logic [1:0]          s1_tuser,
    input  logic                s1_tvalid,
    output logic                s1_tready,
    input  logic [DATA_W-1:0]   s2_tdata,
    input  logic [DATA_W/8-1:0] s2_tstrb,
    input  logic [DATA_W/8-1:0] s2_tkeep,
    input  logic                s2_tlast,
    input  logic [1:0]          s2_tuser,
    input  logic                s2_urgent,
    input  logic                s2_tvalid,
    output logic                s2_tready,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tstrb,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic                m_tlast,
    output logic [1:0]          m_tuser,
    output logic [1:0]          m_tid,
    output logic [SB_W-1:0]     m_tsb,
    output logic                m_tvalid,
    input  logic                m_tready
);
    localparam int KW = DATA_W / 8;

    logic [N_SRC-1:0][DATA_W-1:0] v_data;
    logic [N_SRC-1:0][KW-1:0]     v_strb;
    logic [N_SRC-1:0][KW-1:0]     v_keep;
    logic [N_SRC-1:0][USER_W-1:0] v_user;
    logic [N_SRC-1:0]             v_last;
    logic [N_SRC-1:0]             v_valid;
    logic [N_SRC-1:0]             v_urgent;
    logic [N_SRC-1:0]             v_ready;
    logic                         sel_on;
    logic [IDX_W-1:0]             sel_idx;

    assign v_data   = {s2_tdata, s1_tdata, s0_tdata};
    assign v_strb   = {s2_tstrb, s1_tstrb, s0_tstrb};
    assign v_keep   = {s2_tkeep, s1_tkeep, s0_tkeep};
    assign v_user   = {s2_tuser, s1_tuser, s0_tuser};
    assign v_last   = {s2_tlast, s1_tlast, s0_tlast};
    assign v_valid  = {s2_tvalid, s1_tvalid, s0_tvalid};
    assign v_urgent = {s2_urgent, 1'b0, s0_urgent};

    rr_grant_fsm #(.N(N_SRC), .IW(IDX_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_valid  (v_valid),
        .src_last   (v_last),
        .src_urgent (v_urgent),
        .m_ready    (m_tready),
        .sel_on     (sel_on),
        .sel_idx    (sel_idx),
        .m_valid    (m_tvalid)
    );

    rr_payload_mux #(
        .N(N_SRC), .IW(IDX_W), .DW(DATA_W), .KW(KW),
        .UW(USER_W), .SBW(SB_W), .SB_EN(SB_EN)
    ) mux_i (
        .src_data  (v_data),
        .src_strb  (v_strb),
        .src_keep  (v_keep),
        .src_last  (v_last),
        .src_user  (v_user),
        .sb_in     (s0_tsb),
        .sel_on    (sel_on),
        .sel_idx   (sel_idx),
        .m_ready   (m_tready),
        .m_data    (m_tdata),
        .m_strb    (m_tstrb),
        .m_keep    (m_tkeep),
        .m_last    (m_tlast),
        .m_user    (m_tuser),
        .m_tid     (m_tid),
        .m_sb      (m_tsb),
        .src_ready (v_ready)
    );

    assign s0_tready = v_ready[0];
    assign s1_tready = v_ready[1];
    assign s2_tready = v_ready[2];
endmodule

// File: rtl/rr_stream_merge_chk.sv
module rr_stream_merge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       s0_tvalid,
    input logic       s1_tvalid,
    input logic       s2_tvalid,
    input logic       s0_tready,
    input logic       s1_tready,
    input logic       s2_tready,
    input logic       m_tvalid,
    input logic       m_tready,
    input logic       m_tlast,
    input logic [1:0] m_tid
);
    a_r7_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s2_tready, s1_tready, s0_tready}));

    a_r7_ready_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_tready || s1_tready || s2_tready) |-> m_tready);

    a_r7_ready_matches_tid: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_tready |-> m_tid == 2'd0) and (s1_tready |-> m_tid == 2'd1)
        and (s2_tready |-> m_tid == 2'd2));

    a_r4_packet_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !(m_tready && m_tlast)) |=> (m_tid == $past(m_tid)));

    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> $stable(m_tid));

    a_r6_valid_from_owner: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> ((m_tid == 2'd0 && s0_tvalid) || (m_tid == 2'd1 && s1_tvalid)
                      || (m_tid == 2'd2 && s2_tvalid)));

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(s0_tvalid || s1_tvalid || s2_tvalid) |-> !m_tvalid);
endmodule

bind rr_stream_merge rr_stream_merge_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .s0_tvalid (s0_tvalid),
    .s1_tvalid (s1_tvalid),
    .s2_tvalid (s2_tvalid),
    .s0_tready (s0_tready),
    .s1_tready (s1_tready),
    .s2_tready (s2_tready),
    .m_tvalid  (m_tvalid),
    .m_tready  (m_tready),
    .m_tlast   (m_tlast),
    .m_tid     (m_tid)
);

// File: tb/rr_stream_merge_tb_top.sv
`timescale 1ns/1ps
module rr_stream_merge_tb_top;
    localparam int DW  = 32;
    localparam int KW  = DW / 8;
    localparam int SBW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] s0_tdata, s1_tdata, s2_tdata, m_tdata;
    logic [KW-1:0] s0_tstrb, s1_tstrb, s2_tstrb, m_tstrb;
    logic [KW-1:0] s0_tkeep, s1_tkeep, s2_tkeep, m_tkeep;
    logic s0_tlast, s1_tlast, s2_tlast, m_tlast;
    logic [1:0] s0_tuser, s1_tuser, s2_tuser, m_tuser, m_tid;
    logic [SBW-1:0] s0_tsb, m_tsb;
    logic s0_urgent, s2_urgent;
    logic s0_tvalid, s1_tvalid, s2_tvalid, m_tvalid;
    logic s0_tready, s1_tready, s2_tready, m_tready;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    rr_stream_merge #(.DATA_W(DW), .SB_W(SBW), .SB_EN(1'b1)) dut_i (.*);

    // Row fields: valid{2,1,0} urgent{2,0} last{2,1,0} m_tready | exp valid, tid, ready{2,1,0}
    localparam logic [14:0] TBL [16] = '{
        15'b000_00_000_1_0_00_000, // R8 nothing requested
        15'b111_00_111_1_1_00_001, // R1 first grant is 0
        15'b111_00_111_1_1_01_010, // R2 rotate to 1
        15'b111_00_111_1_1_10_100, // R2 rotate to 2
        15'b111_00_111_1_1_00_001, // R2 wrap to 0
        15'b000_00_000_1_0_00_000, // R8 idle, pointer kept
        15'b101_00_111_1_1_10_100, // R8 search resumes after 0
        15'b111_01_111_1_1_00_001, // R3 urgent 0 wins
        15'b111_11_111_1_1_10_100, // R3 both urgent, rotation picks 2
        15'b110_01_111_1_1_01_010, // R3 urgent without valid ignored
        15'b111_00_000_0_1_10_000, // R7 stalled offer from 2
        15'b111_01_000_1_1_10_100, // R4 mid-packet, urgent 0 waits
        15'b011_01_000_1_0_10_100, // R4 owner gap keeps grant
        15'b111_01_100_1_1_10_100, // R4 tlast beat of 2
        15'b111_01_111_1_1_00_001, // R3 urgent 0 served after packet
        15'b000_00_000_0_0_00_000  // R8 back to idle
    };

    function automatic logic [DW-1:0] word_of(input int i);
        return 32'hC0DE_0000 + DW'(i * 32'h111);
    endfunction

    function automatic string row_tag(input int r);
        case (r)
            0, 5, 15:       return "R8";
            1:              return "R1";
            2, 3, 4:        return "R2";
            6:              return "R8";
            7, 8, 9, 14:    return "R3";
            10:             return "R7";
            default:        return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        s0_tdata = word_of(0); s1_tdata = word_of(1); s2_tdata = word_of(2);
        s0_tstrb = '1; s1_tstrb = '1; s2_tstrb = '1;
        s0_tkeep = '1; s1_tkeep = '1; s2_tkeep = '1;
        s0_tuser = '0; s1_tuser = '0; s2_tuser = '0;
        s0_tlast = 1'b0; s1_tlast = 1'b0; s2_tlast = 1'b0;
        s0_tsb = '0; s0_urgent = 1'b0; s2_urgent = 1'b0;
        s0_tvalid = 1'b0; s1_tvalid = 1'b0; s2_tvalid = 1'b0;
        m_tready = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [14:0] e;
        clear_inputs();
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset m_tvalid", 64'(m_tvalid), 64'd0);
        check("R1 reset readies", 64'({s2_tready, s1_tready, s0_tready}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int r = 0; r < 16; r++) begin
            e = TBL[r];
            @(negedge clk);
            {s2_tvalid, s1_tvalid, s0_tvalid} = e[14:12];
            s2_urgent = e[11];
            s0_urgent = e[10];
            {s2_tlast, s1_tlast, s0_tlast} = e[9:7];
            m_tready = e[6];
            #1;
            check($sformatf("%s row %0d m_tvalid", row_tag(r), r), 64'(m_tvalid), 64'(e[5]));
            check($sformatf("%s row %0d m_tid", row_tag(r), r), 64'(m_tid), 64'(e[4:3]));
            check($sformatf("R7 row %0d readies", r),
                  64'({s2_tready, s1_tready, s0_tready}), 64'(e[2:0]));
            if (e[5]) begin
                check($sformatf("R6 row %0d m_tdata", r), 64'(m_tdata), 64'(word_of(int'(e[4:3]))));
            end
        end

        // R1: reset restarts the search at source 0
        @(negedge clk);
        clear_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        {s2_tvalid, s1_tvalid, s0_tvalid} = 3'b111;
        {s2_tlast, s1_tlast, s0_tlast} = 3'b111;
        #1;
        check("R1 post-reset grant", 64'(m_tid), 64'd0);

        // R6, R9: payload from source 1, sideband blocked
        @(negedge clk);
        clear_inputs();
        s1_tvalid = 1'b1; s1_tlast = 1'b1;
        s1_tstrb = 4'h3; s1_tkeep = 4'h7; s1_tuser = 2'b10;
        s0_tsb = 4'hA;
        #1;
        check("R6 tid src1", 64'(m_tid), 64'd1);
        check("R6 strb src1", 64'(m_tstrb), 64'h3);
        check("R6 keep src1", 64'(m_tkeep), 64'h7);
        check("R6 user src1", 64'(m_tuser), 64'h2);
        check("R6 last src1", 64'(m_tlast), 64'd1);
        check("R9 sideband zero for src1", 64'(m_tsb), 64'd0);
        check("R7 src1 ready", 64'({s2_tready, s1_tready, s0_tready}), 64'b010);

        // R9: sideband from source 0
        @(negedge clk);
        clear_inputs();
        s0_tvalid = 1'b1; s0_tlast = 1'b1;
        s0_tstrb = 4'h5; s0_tuser = 2'b01; s0_tsb = 4'hA;
        #1;
        check("R6 tid src0", 64'(m_tid), 64'd0);
        check("R6 strb src0", 64'(m_tstrb), 64'h5);
        check("R6 user src0", 64'(m_tuser), 64'h1);
        check("R9 sideband src0", 64'(m_tsb), 64'hA);

        // R5: stalled multi-beat offer from source 0 while source 2 asks urgently
        @(negedge clk);
        clear_inputs();
        s0_tvalid = 1'b1; s0_tdata = 32'h1234_5678;
        m_tready = 1'b0;
        #1;
        check("R5 stalled offer valid", 64'(m_tvalid), 64'd1);
        check("R7 stalled readies", 64'({s2_tready, s1_tready, s0_tready}), 64'd0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            s2_tvalid = 1'b1; s2_urgent = 1'b1; s2_tlast = 1'b1;
            #1;
            check($sformatf("R5 stall tid cycle %0d", c), 64'(m_tid), 64'd0);
            check($sformatf("R5 stall data cycle %0d", c), 64'(m_tdata), 64'h1234_5678);
            check($sformatf("R5 stall s2 ready cycle %0d", c), 64'(s2_tready), 64'd0);
        end
        @(negedge clk);
        m_tready = 1'b1; s0_tlast = 1'b1;
        #1;
        check("R4 tlast beat tid", 64'(m_tid), 64'd0);
        check("R4 tlast beat ready", 64'({s2_tready, s1_tready, s0_tready}), 64'b001);
        @(negedge clk);
        s0_tvalid = 1'b0;
        #1;
        check("R3 urgent src2 after packet", 64'(m_tid), 64'd2);
        check("R7 src2 ready", 64'({s2_tready, s1_tready, s0_tready}), 64'b100);

        @(negedge clk);
        clear_inputs();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule